// File: doc/BRIEF.md
# Matrix LCD Refresh Timing Controller

This block drives the continuous refresh of a 240 x 240 monochrome matrix panel. The panel's column side is a chain of three driver segments of 80 pixels each, linked by carry. The row side is a set of common drivers that step through the lines one at a time. The controller reads packed pixel words from an external frame buffer over a plain address/data read port. It presents each word as a 4-bit nibble with a data-clock pulse. Once a whole line has been shifted into the segment chain, it pulses a line clock.

All timing comes from one system-clock divider. One divider period is a tick, and a data-clock pulse lasts two ticks. After the 60th nibble of a line, the line clock goes high for two ticks. An optional idle gap of a few ticks follows. A frame marker rides on the line clock that latches line 0. On that same edge a backplane modulation output changes polarity, so the drive averages to zero DC. With the default divider and a 125 MHz system clock, one frame takes about 13.9 ms, which is inside the 14 ms refresh budget.

Top module: `lcd_refresh_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `pnl_data`, `pnl_dclk`, `pnl_lclk`, `pnl_frame` and `pnl_mod` are all 0, and `fb_addr` is 40, the first word of line 0's pixel 160..239 group.
- R2: Frame buffer word `line*60 + p/4` holds pixels p..p+3 of that line. Within a line, words are sent in this order: offsets 40..59 (pixels 160..239, the segment filled first), then 20..39, then 0..19.
- R3: Bit b of `pnl_data` carries pixel 4*w+b of the current word w, so the lowest pixel index is on bit 0. The word is taken from `fb_rdata` one or more clocks after `fb_addr` presents it (read latency 1). It changes only on a rising `pnl_dclk` and is held while `pnl_dclk` is high, so the panel can sample on the falling edge.
- R4: Each line has exactly 60 data-clock pulses. Each pulse is high for CLK_DIV clocks and low for at least CLK_DIV clocks.
- R5: `pnl_lclk` rises CLK_DIV clocks after the 60th falling data-clock edge of the line. It stays high for exactly 2*CLK_DIV clocks, and `pnl_dclk` is low for that whole time.
- R6: `pnl_frame` is high only while `pnl_lclk` is high, and exactly during the line clock that latches line 0.
- R7: `pnl_mod` changes value only in the clock where a frame-marked line clock rises, and it changes on every such line clock.
- R8: Consecutive frame markers are V_LINES*(2*60+3+GAP_TICKS)*CLK_DIV clocks apart, with 240 line clocks per frame.
- R9: A reset in mid-frame restarts the scan at line 0 with `pnl_mod` cleared. The first line clock after the reset carries the frame marker and sets `pnl_mod` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_addr | output | 14 | Frame-buffer word address |
| fb_rdata | input | 4 | Frame-buffer read data, one clock after the address |
| pnl_data | output | 4 | Pixel nibble to the column-driver chain |
| pnl_dclk | output | 1 | Data clock; the panel samples on the falling edge |
| pnl_lclk | output | 1 | Line clock; latches the shifted line and steps the common drivers |
| pnl_frame | output | 1 | Frame marker, high with the line-0 line clock |
| pnl_mod | output | 1 | Backplane modulation polarity |

## Verification
Every result changes on a tick edge, so each one is due a whole number of CLK_DIV periods after the event that causes it. A nibble appears on the data-clock rise that follows its address by at least one tick. The line clock rises one tick after the last data-clock fall and falls two ticks after it rises. Frame markers repeat after V_LINES line periods. The bench samples on the falling system clock and compares edges it detects against cycle stamps: the data-clock high width must be CLK_DIV, the last-fall-to-line-clock spacing must be CLK_DIV, the line-clock width must be 2*CLK_DIV, and the frame period must be exact. Nibble contents are predicted from a salted hash of the address, together with the expected segment order.

// File: rtl/lcd_refresh_pkg.sv
package lcd_refresh_pkg;

    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_LATCH = 2'd1,
        ST_GAP   = 2'd2
    } scan_st_e;

    function automatic int w_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
    parameter int DIV = 57
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_cnt
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = (cnt_q == CW'(DIV - 1));
                cnt_d = tick ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/lcd_scan_addr.sv
module lcd_scan_addr #(
    parameter int SEGS    = 3,
    parameter int NPS     = 20,
    parameter int LINE_W  = 8,
    parameter int SEG_W   = 2,
    parameter int IDX_W   = 5,
    parameter int ADDR_W  = 14
) (
    input  logic [LINE_W-1:0] line,
    input  logic [SEG_W-1:0]  seg,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int WPL = SEGS * NPS;

    // seg counts fill order; the first-filled segment holds the highest pixels
    always_comb begin
        addr = ADDR_W'(int'(line) * WPL + (SEGS - 1 - int'(seg)) * NPS + int'(idx));
    end
endmodule

// File: rtl/lcd_refresh_ctrl.sv
module lcd_refresh_ctrl
    import lcd_refresh_pkg::*;
#(
    parameter int H_PIX     = 240,
    parameter int V_LINES   = 240,
    parameter int SEGS      = 3,
    parameter int BUS_W     = 4,
    parameter int CLK_DIV   = 57,
    parameter int GAP_TICKS = 4,
    localparam int SEG_PIX       = H_PIX / SEGS,
    localparam int NPS           = SEG_PIX / BUS_W,
    localparam int NIBS_PER_LINE = NPS * SEGS,
    localparam int WORDS         = V_LINES * NIBS_PER_LINE,
    localparam int ADDR_W        = w_of(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] fb_addr,
    input  logic [BUS_W-1:0]  fb_rdata,
    output logic [BUS_W-1:0]  pnl_data,
    output logic              pnl_dclk,
    output logic              pnl_lclk,
    output logic              pnl_frame,
    output logic              pnl_mod
);
    localparam int  LINE_W  = w_of(V_LINES);
    localparam int  SEG_W   = w_of(SEGS);
    localparam int  IDX_W   = w_of(NPS);
    localparam int  GAP_W   = w_of(GAP_TICKS);
    localparam bit  HAS_GAP = (GAP_TICKS > 0);

    typedef struct packed {
        scan_st_e          st;
        logic [1:0]        sub;
        logic [SEG_W-1:0]  seg;
        logic [IDX_W-1:0]  idx;
        logic [LINE_W-1:0] line;
        logic [GAP_W-1:0]  gap;
        logic              dclk;
        logic              lclk;
        logic              frame;
        logic              mod;
        logic [BUS_W-1:0]  data;
    } seq_t;

    seq_t s_d, s_q;
    logic tick;

    lcd_tick_div #(.DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    lcd_scan_addr #(
        .SEGS  (SEGS),
        .NPS   (NPS),
        .LINE_W(LINE_W),
        .SEG_W (SEG_W),
        .IDX_W (IDX_W),
        .ADDR_W(ADDR_W)
    ) u_addr (
        .line(s_q.line),
        .seg (s_q.seg),
        .idx (s_q.idx),
        .addr(fb_addr)
    );

    logic idx_last, seg_last, line_last, line_first, gap_last;

    always_comb begin
        idx_last   = (s_q.idx  == IDX_W'(NPS - 1));
        seg_last   = (s_q.seg  == SEG_W'(SEGS - 1));
        line_last  = (s_q.line == LINE_W'(V_LINES - 1));
        line_first = (s_q.line == '0);
        gap_last   = (s_q.gap  == GAP_W'(GAP_TICKS - 1));

        s_d = s_q;
        if (tick) begin
            unique case (s_q.st)
                ST_SHIFT: begin
                    if (s_q.sub == 2'd0) begin
                        // rising data clock presents the prefetched word
                        s_d.dclk = 1'b1;
                        s_d.data = fb_rdata;
                        s_d.sub  = 2'd1;
                    end else begin
                        // falling data clock; step to the next word
                        s_d.dclk = 1'b0;
                        s_d.sub  = 2'd0;
                        if (idx_last) begin
                            s_d.idx = '0;
                            if (seg_last) begin
                                s_d.seg = '0;
                                s_d.st  = ST_LATCH;
                            end else begin
                                s_d.seg = s_q.seg + 1'b1;
                            end
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end
                end
                ST_LATCH: begin
                    unique case (s_q.sub)
                        2'd0: begin
                            s_d.lclk  = 1'b1;
                            s_d.frame = line_first;
                            s_d.mod   = s_q.mod ^ line_first;
                            s_d.line  = line_last ? '0 : s_q.line + 1'b1;
                            s_d.sub   = 2'd1;
                        end
                        2'd1: s_d.sub = 2'd2;
                        default: begin
                            s_d.lclk  = 1'b0;
                            s_d.frame = 1'b0;
                            s_d.sub   = 2'd0;
                            s_d.gap   = '0;
                            s_d.st    = HAS_GAP ? ST_GAP : ST_SHIFT;
                        end
                    endcase
                end
                ST_GAP: begin
                    if (gap_last) s_d.st  = ST_SHIFT;
                    else          s_d.gap = s_q.gap + 1'b1;
                end
                default: s_d.st = ST_SHIFT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pnl_data  = s_q.data;
    assign pnl_dclk  = s_q.dclk;
    assign pnl_lclk  = s_q.lclk;
    assign pnl_frame = s_q.frame;
    assign pnl_mod   = s_q.mod;

endmodule

// File: rtl/lcd_refresh_chk.sv
module lcd_refresh_chk #(
    parameter int NIBS    = 60,
    parameter int CLK_DIV = 57,
    parameter int BUS_W   = 4,
    parameter int ADDR_W  = 14,
    parameter int WORDS   = 14400
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fb_addr,
    input logic [BUS_W-1:0]  pnl_data,
    input logic              pnl_dclk,
    input logic              pnl_lclk,
    input logic              pnl_frame,
    input logic              pnl_mod
);
    logic        dclk_p, lclk_p;
    logic [15:0] nib_cnt, lhi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dclk_p  <= 1'b0;
            lclk_p  <= 1'b0;
            nib_cnt <= '0;
            lhi_cnt <= '0;
        end else begin
            dclk_p <= pnl_dclk;
            lclk_p <= pnl_lclk;
            if (pnl_lclk && !lclk_p)       nib_cnt <= '0;
            else if (pnl_dclk && !dclk_p)  nib_cnt <= nib_cnt + 1'b1;
            lhi_cnt <= pnl_lclk ? lhi_cnt + 1'b1 : '0;
        end
    end

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pnl_lclk && pnl_dclk));

    p_lclk_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pnl_lclk) |-> (lhi_cnt == 16'(2 * CLK_DIV)));

    p_nib_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pnl_lclk) |-> (nib_cnt == 16'(NIBS)));

    p_nib_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nib_cnt <= 16'(NIBS));

    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pnl_dclk && $past(pnl_dclk)) |-> $stable(pnl_data));

    p_frame_in_lclk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pnl_frame |-> pnl_lclk);

    p_mod_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pnl_mod) |-> ($rose(pnl_lclk) && pnl_frame));

    p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fb_addr) < WORDS);

endmodule

bind lcd_refresh_ctrl lcd_refresh_chk #(
    .NIBS   (NIBS_PER_LINE),
    .CLK_DIV(CLK_DIV),
    .BUS_W  (BUS_W),
    .ADDR_W (ADDR_W),
    .WORDS  (WORDS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fb_addr  (fb_addr),
    .pnl_data (pnl_data),
    .pnl_dclk (pnl_dclk),
    .pnl_lclk (pnl_lclk),
    .pnl_frame(pnl_frame),
    .pnl_mod  (pnl_mod)
);

// File: tb/test_lcd_refresh_ctrl.sv
module test_lcd_refresh_ctrl;
    localparam int DIV  = 2;
    localparam int GAP  = 3;
    localparam int V    = 240;
    localparam int SEGS = 3;
    localparam int NPS  = 20;
    localparam int NIBS = 60;
    localparam int AW   = 14;
    localparam int FRAME_CLKS = V * (2 * NIBS + 3 + GAP) * DIV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fb_addr;
    logic [3:0]    fb_rdata = '0;
    logic [3:0]    pnl_data;
    logic          pnl_dclk, pnl_lclk, pnl_frame, pnl_mod;

    always #4 clk = ~clk;

    lcd_refresh_ctrl #(.CLK_DIV(DIV), .GAP_TICKS(GAP)) i_lcd_refresh_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .fb_addr  (fb_addr),
        .fb_rdata (fb_rdata),
        .pnl_data (pnl_data),
        .pnl_dclk (pnl_dclk),
        .pnl_lclk (pnl_lclk),
        .pnl_frame(pnl_frame),
        .pnl_mod  (pnl_mod)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int unsigned salt = 0;
    bit done = 0;

    function automatic logic [3:0] mem_word(input int unsigned a, input int unsigned s);
        logic [31:0] h;
        h = (a * 32'h9E3779B1) ^ s;
        return h[3:0] ^ h[21:18];
    endfunction

    function automatic int word_of(input int k);
        return (SEGS - 1 - k / NPS) * NPS + k % NPS;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // frame buffer model, read latency one clock
    always @(posedge clk) begin
        cyc      <= cyc + 1;
        fb_rdata <= mem_word(int'(fb_addr), salt);
    end

    int   e_line, e_nib, dhi, lhi, lclk_cnt, last_frame, last_fall, frames_seen = 0;
    bit   have_frame, overlap;
    logic p_dclk, p_lclk, p_mod;
    logic [3:0] p_data;

    always @(negedge clk) begin
        if (!rst_n) begin
            e_line = 0; e_nib = 0; dhi = 0; lhi = 0; lclk_cnt = 0;
            have_frame = 0; overlap = 0; last_fall = 0;
            p_dclk = 0; p_lclk = 0; p_mod = 0; p_data = '0;
        end else begin
            if (pnl_dclk) begin
                dhi++;
                if (p_dclk) check(pnl_data == p_data, "R3 data held while dclk high",
                                  int'(pnl_data), int'(p_data));
            end
            if (p_dclk && !pnl_dclk) begin
                check(dhi == DIV, "R4 dclk high width", dhi, DIV);
                check(pnl_data == mem_word(e_line * NIBS + word_of(e_nib), salt),
                      "R2 R3 nibble order/content", int'(pnl_data),
                      int'(mem_word(e_line * NIBS + word_of(e_nib), salt)));
                e_nib++;
                dhi = 0;
                last_fall = cyc;
            end
            if (pnl_lclk && pnl_dclk) overlap = 1;
            if (pnl_lclk) lhi++;
            if (pnl_lclk && !p_lclk) begin
                check(e_nib == NIBS, "R4 nibbles per line", e_nib, NIBS);
                check(cyc - last_fall == DIV, "R5 lclk after last fall", cyc - last_fall, DIV);
                check(pnl_frame == (e_line == 0), "R6 frame marker", int'(pnl_frame), int'(e_line == 0));
                check((pnl_mod != p_mod) == (e_line == 0), "R7 mod toggle", int'(pnl_mod != p_mod),
                      int'(e_line == 0));
                if (e_line == 0) begin
                    if (have_frame) begin
                        check(cyc - last_frame == FRAME_CLKS, "R8 frame period", cyc - last_frame, FRAME_CLKS);
                        check(lclk_cnt == V, "R8 line clocks per frame", lclk_cnt, V);
                    end
                    have_frame = 1;
                    last_frame = cyc;
                    lclk_cnt = 0;
                    frames_seen++;
                end
                lclk_cnt++;
                e_nib = 0;
                e_line = (e_line + 1) % V;
            end
            if (!pnl_lclk && p_lclk) begin
                check(lhi == 2 * DIV, "R5 lclk width", lhi, 2 * DIV);
                check(!overlap, "R5 dclk low during lclk", int'(overlap), 0);
                lhi = 0;
                overlap = 0;
            end
            if (pnl_frame && !pnl_lclk) check(0, "R6 frame without lclk", 1, 0);
            if ((pnl_mod != p_mod) && !(pnl_lclk && !p_lclk)) check(0, "R7 stray mod change", 1, 0);
            p_dclk = pnl_dclk; p_lclk = pnl_lclk; p_mod = pnl_mod; p_data = pnl_data;
        end
    end

    task automatic check_reset_outs(input string tag);
        check(pnl_dclk == 0 && pnl_lclk == 0 && pnl_frame == 0, {tag, " strobes low"},
              int'({pnl_dclk, pnl_lclk, pnl_frame}), 0);
        check(pnl_mod == 0, {tag, " mod low"}, int'(pnl_mod), 0);
        check(pnl_data == 0, {tag, " data low"}, int'(pnl_data), 0);
        check(fb_addr == 40, {tag, " first address"}, int'(fb_addr), 40);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        salt = $urandom;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_outs("R1");
        rst_n = 1'b1;
        // three frame markers: two full frame periods including the 239 -> 0 wrap
        while (frames_seen < 3) @(negedge clk);
        repeat ($urandom_range(5000, 1000)) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_outs("R9");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        while (frames_seen < 4) @(negedge clk);
        check(pnl_mod == 1, "R9 mod after restart", int'(pnl_mod), 1);
        check(pnl_frame == 1, "R9 restart at line 0", int'(pnl_frame), 1);
        repeat (2000) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end
endmodule